// File: doc/BRIEF.md
# SPI Serial Static RAM Slave

This block is a byte-wide static memory that a host reaches over a four-wire synchronous serial link. The link has separate input and output data lines, an active-high chip enable and an active-low slave select. It runs in clock mode 3: the serial clock idles high, and bits travel most significant first. Every transaction opens with one command byte. The top bit of that byte picks the direction, and the low seven bits give a starting word address. A separate address pin chooses which of the two 128-word halves is used.

Any number of data bytes may follow the command within one selection. The word address steps by one after each byte and wraps inside the selected half. Dropping either enable ends the transaction, discards any partial byte, and makes the next selection start with a new command.

The serial clock, enables, data input and half-select pin are brought into the block clock domain through a short synchronizer, and serial clock edges are detected there. The serial port carries no valid/ready handshake, and there is no back-pressure: the host sets the pace through the serial clock. The serial clock must therefore stay in each level for several block clock cycles. With the default two-stage synchronizer, at least six cycles per level is enough.

Top module: `spi_sram_slave`

## Requirements
- R1: Serial traffic has an effect only while `ce` is 1 and `ss_n` is 0 at the same time. Clocking a complete write frame with `ce` at 0, or with `ss_n` at 1, leaves the memory unchanged and keeps `sdo_oe` at 0.
- R2: Dropping the selection discards any partial byte and any command state. A write cut short before its eighth data bit stores nothing, and the next selection treats its first byte as a command.
- R3: The first byte of a selection is a command. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6..0 hold the starting word address within the half.
- R4: In a write, `sdi` is sampled on rising `sck` edges, most significant bit first. The byte is stored only after its eighth bit, and no other word changes.
- R5: In a read, the addressed word appears on `sdo` most significant bit first. Each bit changes on a falling `sck` edge. The first bit is driven on the falling edge that follows the command's last rising edge.
- R6: After each complete data byte, the 7-bit word address increments and wraps from 127 to 0. The half-select pin is unaffected, both for writes and for reads.
- R7: `addr_hi` supplies address bit 7, so the two halves keep independent contents.
- R8: `sdo_oe` is 1 only while selected in a read. `sdo` is 0 whenever `sdo_oe` is 0.
- R9: After reset, `sdo` and `sdo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idles high |
| ce | input | 1 | Chip enable, active high |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| addr_hi | input | 1 | Word address bit 7 (half select) |
| sdo | output | 1 | Serial data out, 0 when not driving |
| sdo_oe | output | 1 | Output enable for an external pad driver |

## Verification
Most wrong internal states show up at the ports within one byte. A bit counter or command decode that is off misplaces every later byte of the burst. An address counter that skips or wraps wrongly returns the wrong word on the next read byte. A store that happens early, or one that survives deselection, appears only when that word is read back later. The bench therefore writes both halves completely and reads every word back across the wrap points. It also probes the cut-short and disabled cases with a targeted read directly afterwards.

// File: rtl/spiram_pkg.sv
package spiram_pkg;
  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_RD  = 2'd1,
    PH_WR  = 2'd2
  } phase_e;
endpackage

// File: rtl/spiram_sync.sv
module spiram_sync #(
  parameter int          N      = 4,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spiram_shift.sv
module spiram_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rise,
  input  logic          bit_in,
  output logic          byte_done,
  output logic [DW-1:0] byte_val
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sh_q      <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else if (!sel) begin
      cnt_q     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        sh_q <= {sh_q[DW-2:0], bit_in};
        if (cnt_q == LAST) begin
          cnt_q     <= '0;
          byte_done <= 1'b1;
          byte_val  <= {sh_q[DW-2:0], bit_in};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spiram_ctrl.sv
module spiram_ctrl
  import spiram_pkg::*;
#(
  parameter int LO_AW = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             fall,
  input  logic             byte_done,
  input  logic [DW-1:0]    byte_val,
  input  logic [DW-1:0]    rd_data,
  output logic [LO_AW-1:0] mem_addr_lo,
  output logic             mem_we,
  output logic [LO_AW-1:0] addr_q,
  output phase_e           phase_q,
  output logic             out_bit,
  output logic             out_en
);
  logic [DW-1:0]    osr_q;
  logic [LO_AW-1:0] cmd_addr;
  logic             cmd_write;

  assign cmd_addr    = byte_val[LO_AW-1:0];
  assign cmd_write   = byte_val[DW-1];
  assign mem_addr_lo = (phase_q == PH_CMD) ? cmd_addr : addr_q;
  assign mem_we      = sel && byte_done && (phase_q == PH_WR);
  assign out_en      = sel && (phase_q == PH_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      osr_q   <= '0;
      out_bit <= 1'b0;
    end else if (!sel) begin
      phase_q <= PH_CMD;
      out_bit <= 1'b0;
    end else if (byte_done) begin
      case (phase_q)
        PH_CMD: begin
          out_bit <= 1'b0;
          if (cmd_write) begin
            phase_q <= PH_WR;
            addr_q  <= cmd_addr;
          end else begin
            phase_q <= PH_RD;
            osr_q   <= rd_data;
            addr_q  <= cmd_addr + 1'b1;
          end
        end
        PH_RD: begin
          osr_q  <= rd_data;
          addr_q <= addr_q + 1'b1;
        end
        default: addr_q <= addr_q + 1'b1;
      endcase
    end else if (fall && phase_q == PH_RD) begin
      out_bit <= osr_q[DW-1];
      osr_q   <= {osr_q[DW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spiram_array.sv
module spiram_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import spiram_pkg::*;
#(
  parameter int LO_AW = 7,
  parameter int HI_AW = 1,
  parameter int DW    = 8,
  parameter int SYNC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic ce,
  input  logic ss_n,
  input  logic sdi,
  input  logic addr_hi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int AW = LO_AW + HI_AW;
  localparam int NS = 5;

  logic [NS-1:0]    raw, syn;
  logic             sck_s, ce_s, ss_s, sdi_s, hi_s;
  logic             sck_d, sel, rise, fall;
  logic             byte_done, mem_we, out_bit;
  logic [DW-1:0]    byte_val, rd_data;
  logic [LO_AW-1:0] mem_addr_lo, addr_q;
  logic [AW-1:0]    mem_addr;
  phase_e           phase_q;

  assign raw = {addr_hi, sdi, ss_n, ce, sck};

  spiram_sync #(.N(NS), .STAGES(SYNC), .INIT(5'b00101)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {hi_s, sdi_s, ss_s, ce_s, sck_s} = syn;
  assign sel = ce_s & ~ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b1;
    else        sck_d <= sck_s;
  end

  assign rise = sel &  sck_s & ~sck_d;
  assign fall = sel & ~sck_s &  sck_d;

  spiram_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rise(rise), .bit_in(sdi_s),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  spiram_ctrl #(.LO_AW(LO_AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .fall(fall),
    .byte_done(byte_done), .byte_val(byte_val), .rd_data(rd_data),
    .mem_addr_lo(mem_addr_lo), .mem_we(mem_we), .addr_q(addr_q),
    .phase_q(phase_q), .out_bit(out_bit), .out_en(sdo_oe)
  );

  generate
    if (HI_AW > 0) begin : g_hi
      assign mem_addr = {{(HI_AW-1){1'b0}}, hi_s, mem_addr_lo};
    end else begin : g_lo
      assign mem_addr = mem_addr_lo;
    end
  endgenerate

  spiram_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(byte_val), .rdata(rd_data)
  );

  assign sdo = sdo_oe & out_bit;
endmodule

// File: rtl/spi_sram_checker.sv
module spi_sram_checker #(
  parameter int LO_AW = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             fall,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             mem_we,
  input logic             byte_done,
  input logic [1:0]       phase,
  input logic [LO_AW-1:0] addr_q
);
  assert_oe_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> sel);

  assert_store_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> sel);

  assert_store_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> byte_done);

  assert_first_bit_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  assert_bit_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !fall) |=> (!sdo_oe || sdo == $past(sdo)));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase != 2'd0) |=> addr_q == LO_AW'($past(addr_q) + 1'b1));

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

bind spi_sram_slave spi_sram_checker #(.LO_AW(LO_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .fall(fall), .sdo(sdo), .sdo_oe(sdo_oe),
  .mem_we(mem_we), .byte_done(byte_done), .phase(phase_q), .addr_q(addr_q)
);

// File: tb/tb_spi_sram_slave.sv
module tb_spi_sram_slave;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, ce = 1'b0, ss_n = 1'b1, sdi = 1'b0, addr_hi = 1'b0;
  logic sdo, sdo_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] expm [256];

  always #5 clk = ~clk;

  spi_sram_slave dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ce(ce), .ss_n(ss_n), .sdi(sdi),
    .addr_hi(addr_hi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  function automatic logic [7:0] pat(input int a, input int pass);
    return 8'((a * 13 + 8'h6B + pass * 8'h35) ^ (a >> 3));
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_bit(input logic b, output logic got, output logic oe);
    sck = 1'b0;
    sdi = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    got = sdo;
    oe  = sdo_oe;
    sck = 1'b1;
    repeat (HALF) @(posedge clk);
  endtask

  task automatic do_byte(input logic [7:0] b, output logic [7:0] got, output logic any_oe,
                         output logic all_oe);
    logic g, o;
    any_oe = 1'b0;
    all_oe = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      do_bit(b[i], g, o);
      got[i] = g;
      any_oe |= o;
      all_oe &= o;
    end
  endtask

  task automatic sel_on;
    ce = 1'b1; ss_n = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic sel_off;
    ss_n = 1'b1; ce = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic write_burst(input logic hi, input int start, input int n, input int pass);
    logic [7:0] g;
    logic ao, al;
    int a;
    addr_hi = hi;
    sel_on();
    do_byte(8'h80 | 8'(start), g, ao, al);
    for (int k = 0; k < n; k++) begin
      a = (start + k) % 128;
      expm[{hi, 7'(a)}] = pat({hi, 7'(a)}, pass);
      do_byte(expm[{hi, 7'(a)}], g, ao, al);
      if (k == 0 || k == n - 1)
        check(ao == 1'b0, "R8 oe low during write", ao, 0);
    end
    sel_off();
  endtask

  task automatic read_burst(input logic hi, input int start, input int n, input string tag);
    logic [7:0] g;
    logic ao, al;
    int a;
    addr_hi = hi;
    sel_on();
    do_byte(8'(start) & 8'h7F, g, ao, al);
    check(ao == 1'b0, "R3 oe low during command", ao, 0);
    for (int k = 0; k < n; k++) begin
      a = {hi, 7'((start + k) % 128)};
      do_byte(8'hFF, g, ao, al);
      check(g == expm[a], tag, g, expm[a]);
      check(al == 1'b1, "R8 oe high during read", al, 1);
    end
    sel_off();
    check(sdo_oe == 1'b0 && sdo == 1'b0, "R8 quiet after deselect", {sdo_oe, sdo}, 0);
  endtask

  initial begin
    logic [7:0] g;
    logic ao, al, gb, ob;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sdo == 1'b0 && sdo_oe == 1'b0, "R9 reset outputs", {sdo_oe, sdo}, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R4 R6 R7: fill both halves with wrapping write bursts
    write_burst(1'b0, 5, 128, 0);
    write_burst(1'b1, 64, 128, 0);

    // R5 R6 R7 R3: read every word back, across the wrap
    read_burst(1'b0, 126, 130, "R6 read wrap half 0");
    read_burst(1'b1, 126, 130, "R7 read wrap half 1");

    // R3: single-byte reads at scattered addresses
    for (int a = 0; a < 128; a += 37) read_burst(1'b0, a, 1, "R3 single read");

    // R2: write cut short after 5 data bits stores nothing
    addr_hi = 1'b0;
    sel_on();
    do_byte(8'h89, g, ao, al);
    for (int i = 0; i < 5; i++) do_bit(1'b1, gb, ob);
    sel_off();
    read_burst(1'b0, 9, 1, "R2 partial byte discarded");

    // R2: command cut short, next selection starts with a fresh command
    sel_on();
    do_bit(1'b1, gb, ob); do_bit(1'b0, gb, ob); do_bit(1'b1, gb, ob);
    sel_off();
    read_burst(1'b0, 10, 2, "R2 fresh command after abort");

    // R1: chip enable low, slave select active
    ce = 1'b0; ss_n = 1'b0; addr_hi = 1'b0;
    repeat (4) @(posedge clk);
    do_byte(8'h8C, g, ao, al);
    do_byte(8'h00, g, ao, al);
    check(ao == 1'b0, "R1 oe with ce low", ao, 0);
    sel_off();
    read_burst(1'b0, 12, 1, "R1 ce low ignored");

    // R1: chip enable high, slave select inactive
    ce = 1'b1; ss_n = 1'b1;
    repeat (4) @(posedge clk);
    do_byte(8'h0C, g, ao, al);
    do_byte(8'h00, g, ao, al);
    check(ao == 1'b0, "R1 oe with ss high", ao, 0);
    do_byte(8'h8C, g, ao, al);
    do_byte(8'h00, g, ao, al);
    sel_off();
    read_burst(1'b0, 12, 1, "R1 ss high ignored");

    // R4: single overwrite changes only its word
    write_burst(1'b1, 20, 1, 3);
    read_burst(1'b1, 19, 3, "R4 single overwrite");
    read_burst(1'b0, 20, 1, "R7 other half untouched");

    // R6: write burst wrapping 127 -> 0 in half 1
    write_burst(1'b1, 126, 4, 5);
    read_burst(1'b1, 125, 6, "R6 write wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule